// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is an 8-bit accumulator datapath. It has an arithmetic/logic function, a registered accumulator, and a registered set of five status flags: sign, zero, carry, parity and auxiliary (half) carry. Each clock cycle in which the enable input is high, the block applies one operation to the accumulator. The operation takes the accumulator, the external operand and, where the operation needs it, the stored carry flag. The block then writes the result and the flags that the operation affects.

The operations are:
- add and subtract, each with and without carry
- increment and decrement
- the bitwise AND, OR and XOR
- complement
- compare
- the circular and through-carry rotates in both directions
- set carry and complement carry
- a plain load of the operand into the accumulator

Every operation has its own rule for which flags change. Compare computes flags only. Rotates touch the carry flag alone. Increment and decrement leave the carry flag as it was.

Top module: `acc_alu`

## Requirements
- R1: While reset is high at a clock edge, the accumulator and all five flags become 0.
- R2: When the enable input is low, a clock edge changes neither the accumulator nor any flag. Code LOAD copies the operand into the accumulator and leaves all flags unchanged.
- R3: ADD writes (A + B) mod 256. ADC writes (A + B + C) mod 256, where C is the stored carry flag. The carry flag becomes the carry out of bit 7. The auxiliary flag becomes the carry out of bit 3 of the same sum.
- R4: SUB writes (A - B) mod 256. SBB writes (A - B - C) mod 256. The carry flag becomes the borrow, which is 1 when B (plus C for SBB) exceeds A as unsigned values. The auxiliary flag is the carry out of bit 3 of A + ~B + (1 - borrow-in).
- R5: CMP sets all five flags exactly as SUB would for the same inputs and does not write the accumulator.
- R6: INC adds 1 and DEC subtracts 1 from the accumulator. Sign, zero, parity and auxiliary flags update; the carry flag keeps its value. The auxiliary flag is set for INC when the old low nibble was 0xF, and for DEC when the old low nibble was nonzero.
- R7: AND, OR and XOR write the bitwise result, clear the carry and auxiliary flags, and update sign, zero and parity.
- R8: For every operation that updates them, the sign flag equals bit 7 of the result, the zero flag is 1 exactly when all 8 result bits are 0, and the parity flag is 1 exactly when the result has an even number of ones.
- R9: RLC rotates the accumulator left with bit 7 entering both bit 0 and the carry flag. RRC rotates right with bit 0 entering both bit 7 and the carry flag. No other flag changes.
- R10: RAL shifts left with the old carry entering bit 0 and bit 7 entering the carry flag. RAR shifts right with the old carry entering bit 7 and bit 0 entering the carry flag. No other flag changes.
- R11: STC sets the carry flag to 1 and CMC inverts it; neither changes the accumulator or any other flag. CPL inverts every accumulator bit and changes no flag.
- R12: Operation codes on the 5-bit input are:
  - LOAD=0, ADD=1, ADC=2, SUB=3, SBB=4, CMP=5
  - INC=6, DEC=7, AND=8, OR=9, XOR=10, CPL=11
  - RLC=12, RRC=13, RAL=14, RAR=15, STC=16, CMC=17

  Codes 18 to 31 leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Apply the selected operation at this edge |
| op_code | input | 5 | Operation select (see R12) |
| operand | input | 8 | Second operand B |
| acc_o | output | 8 | Registered accumulator |
| flag_sign | output | 1 | Registered sign flag |
| flag_zero | output | 1 | Registered zero flag |
| flag_carry | output | 1 | Registered carry / borrow flag |
| flag_parity | output | 1 | Registered even-parity flag |
| flag_aux | output | 1 | Registered auxiliary carry flag |

## Verification
The bench builds the block with its default width of 8 and the half-carry boundary at bit 4. At that size, every one of the 256 accumulator values can be swept against a spread of operands that includes 0 and 0xFF.

The two-operand operations run with both carry states. The unary and rotate operations run over every accumulator value, with both carry states for the rotates. This puts the bit-3 carry, the bit-7 carry and borrow, and the zero and wrap-around results within reach.

Idle cycles, unused codes and the carry set/complement sequence are checked against a model in the bench that tracks all state arithmetically.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 5'd0,
        OP_ADD  = 5'd1,
        OP_ADC  = 5'd2,
        OP_SUB  = 5'd3,
        OP_SBB  = 5'd4,
        OP_CMP  = 5'd5,
        OP_INC  = 5'd6,
        OP_DEC  = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_CPL  = 5'd11,
        OP_RLC  = 5'd12,
        OP_RRC  = 5'd13,
        OP_RAL  = 5'd14,
        OP_RAR  = 5'd15,
        OP_STC  = 5'd16,
        OP_CMC  = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
        logic p;
        logic ac;
    } alu_flags_t;

    typedef struct packed {
        logic use_arith;
        logic wr_acc;
        logic upd_szp;
        logic upd_c;
        logic upd_ac;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_ctl(input alu_op_e op);
        alu_ctl_t k;
        k = '0;
        case (op)
            OP_LOAD: k.wr_acc = 1'b1;
            OP_ADD, OP_ADC, OP_SUB, OP_SBB:
                k = '{use_arith: 1'b1, wr_acc: 1'b1, upd_szp: 1'b1, upd_c: 1'b1, upd_ac: 1'b1};
            OP_CMP:
                k = '{use_arith: 1'b1, wr_acc: 1'b0, upd_szp: 1'b1, upd_c: 1'b1, upd_ac: 1'b1};
            OP_INC, OP_DEC:
                k = '{use_arith: 1'b1, wr_acc: 1'b1, upd_szp: 1'b1, upd_c: 1'b0, upd_ac: 1'b1};
            OP_AND, OP_OR, OP_XOR:
                k = '{use_arith: 1'b0, wr_acc: 1'b1, upd_szp: 1'b1, upd_c: 1'b1, upd_ac: 1'b1};
            OP_CPL: k.wr_acc = 1'b1;
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                k.wr_acc = 1'b1;
                k.upd_c  = 1'b1;
            end
            OP_STC, OP_CMC: k.upd_c = 1'b1;
            default: k = '0;
        endcase
        return k;
    endfunction

    function automatic logic is_rotate(input alu_op_e op);
        return (op == OP_RLC) || (op == OP_RRC) || (op == OP_RAL) || (op == OP_RAR);
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int AUX_BIT = 4
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             aux
);
    localparam int SUM_W = WIDTH + 1;
    localparam int LO_W  = AUX_BIT + 1;

    logic [WIDTH-1:0] addend;
    logic             carry_in;
    logic             borrow_sense;
    logic [SUM_W-1:0] sum_full;
    logic [LO_W-1:0]  sum_low;

    always_comb begin
        addend       = b;
        carry_in     = 1'b0;
        borrow_sense = 1'b0;
        case (op)
            OP_ADD: ;
            OP_ADC: carry_in = cin;
            OP_SUB, OP_CMP: begin
                addend       = ~b;
                carry_in     = 1'b1;
                borrow_sense = 1'b1;
            end
            OP_SBB: begin
                addend       = ~b;
                carry_in     = ~cin;
                borrow_sense = 1'b1;
            end
            OP_INC: begin
                addend   = '0;
                carry_in = 1'b1;
            end
            OP_DEC: addend = '1;
            default: ;
        endcase
    end

    assign sum_full = {1'b0, a} + {1'b0, addend} + {{WIDTH{1'b0}}, carry_in};
    assign sum_low  = {1'b0, a[AUX_BIT-1:0]} + {1'b0, addend[AUX_BIT-1:0]}
                    + {{AUX_BIT{1'b0}}, carry_in};

    assign res  = sum_full[WIDTH-1:0];
    assign cout = sum_full[WIDTH] ^ borrow_sense;
    assign aux  = sum_low[AUX_BIT];

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        res  = a;
        cout = 1'b0;
        case (op)
            OP_LOAD: res = b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CPL:  res = ~a;
            OP_RLC: begin
                res  = {a[MSB-1:0], a[MSB]};
                cout = a[MSB];
            end
            OP_RRC: begin
                res  = {a[0], a[MSB:1]};
                cout = a[0];
            end
            OP_RAL: begin
                res  = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            OP_RAR: begin
                res  = {cin, a[MSB:1]};
                cout = a[0];
            end
            OP_STC: cout = 1'b1;
            OP_CMC: cout = ~cin;
            default: cout = cin;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int AUX_BIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_en,
    input  logic [OP_W-1:0]  op_code,
    input  logic [WIDTH-1:0] operand,
    output logic [WIDTH-1:0] acc_o,
    output logic             flag_sign,
    output logic             flag_zero,
    output logic             flag_carry,
    output logic             flag_parity,
    output logic             flag_aux
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op;
    alu_ctl_t         ctl;
    logic [WIDTH-1:0] acc_q;
    alu_flags_t       flags_q;
    alu_flags_t       flags_d;
    logic [WIDTH-1:0] arith_res;
    logic             arith_c;
    logic             arith_ac;
    logic [WIDTH-1:0] bit_res;
    logic             bit_c;
    logic [WIDTH-1:0] result;

    assign op  = alu_op_e'(op_code);
    assign ctl = decode_ctl(op);

    acc_alu_arith #(.WIDTH(WIDTH), .AUX_BIT(AUX_BIT)) u_arith (
        .op   (op),
        .a    (acc_q),
        .b    (operand),
        .cin  (flags_q.c),
        .res  (arith_res),
        .cout (arith_c),
        .aux  (arith_ac)
    );

    acc_alu_bitops #(.WIDTH(WIDTH)) u_bitops (
        .op   (op),
        .a    (acc_q),
        .b    (operand),
        .cin  (flags_q.c),
        .res  (bit_res),
        .cout (bit_c)
    );

    assign result = ctl.use_arith ? arith_res : bit_res;

    always_comb begin
        flags_d = flags_q;
        if (ctl.upd_szp) begin
            flags_d.s = result[MSB];
            flags_d.z = ~|result;
            flags_d.p = ~^result;
        end
        if (ctl.upd_c)  flags_d.c  = ctl.use_arith ? arith_c : bit_c;
        if (ctl.upd_ac) flags_d.ac = ctl.use_arith ? arith_ac : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (op_en) begin
            if (ctl.wr_acc) acc_q <= result;
            flags_q <= flags_d;
        end
    end

    assign acc_o       = acc_q;
    assign flag_sign   = flags_q.s;
    assign flag_zero   = flags_q.z;
    assign flag_carry  = flags_q.c;
    assign flag_parity = flags_q.p;
    assign flag_aux    = flags_q.ac;

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (acc_o == '0) && (flags_q == '0)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op_en |=> $stable(acc_o) && $stable(flags_q)); // R2
    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code == OP_CMP) |=> $stable(acc_o)); // R5
    AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_en && (op_code == OP_INC || op_code == OP_DEC)) |=> $stable(flag_carry)); // R6
    AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_en && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR))
        |=> !flag_carry && !flag_aux); // R7
    AST_ZERO_MATCHES_ACC: assert property (@(posedge clk) disable iff (rst)
        (op_en && (op_code == OP_ADD || op_code == OP_SUB || op_code == OP_XOR))
        |=> flag_zero == (acc_o == '0)); // R8
    AST_ROTATE_ONLY_CARRY: assert property (@(posedge clk) disable iff (rst)
        (op_en && is_rotate(op)) |=> $stable(flag_sign) && $stable(flag_zero)
        && $stable(flag_parity) && $stable(flag_aux)); // R9
    AST_STC_SETS: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code == OP_STC) |=> flag_carry && $stable(acc_o)); // R11
    AST_CMC_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code == OP_CMC) |=> flag_carry != $past(flag_carry)); // R11
    AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code > OP_CMC) |=> $stable(acc_o) && $stable(flags_q)); // R12

endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    import acc_alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_en = 1'b0;
    logic [4:0] op_code = 5'd0;
    logic [7:0] operand = 8'd0;
    logic [7:0] acc_o;
    logic       flag_sign, flag_zero, flag_carry, flag_parity, flag_aux;

    int n_cmp = 0;
    int n_bad = 0;

    int m_acc = 0;
    bit m_s = 0, m_z = 0, m_c = 0, m_p = 0, m_ac = 0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code), .operand(operand),
        .acc_o(acc_o), .flag_sign(flag_sign), .flag_zero(flag_zero),
        .flag_carry(flag_carry), .flag_parity(flag_parity), .flag_aux(flag_aux)
    );

    task automatic set_szp(input int r);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        m_s = (r >= 128);
        m_z = (r == 0);
        m_p = (ones % 2 == 0);
    endtask

    task automatic model_op(input int op, input int b);
        int a = m_acc;
        int r;
        int ci;
        case (op)
            0: m_acc = b;
            1, 2: begin
                ci = (op == 2) ? int'(m_c) : 0;
                r = a + b + ci;
                m_ac = ((a % 16) + (b % 16) + ci) > 15;
                m_c = (r > 255);
                m_acc = r % 256;
                set_szp(m_acc);
            end
            3, 4, 5: begin
                ci = (op == 4) ? int'(m_c) : 0;
                r = a - b - ci;
                m_ac = ((a % 16) + (15 - b % 16) + 1 - ci) > 15;
                m_c = (r < 0);
                r = (r + 512) % 256;
                if (op != 5) m_acc = r;
                set_szp(r);
            end
            6: begin
                m_ac = (a % 16) == 15;
                m_acc = (a + 1) % 256;
                set_szp(m_acc);
            end
            7: begin
                m_ac = (a % 16) != 0;
                m_acc = (a + 255) % 256;
                set_szp(m_acc);
            end
            8, 9, 10: begin
                m_acc = (op == 8) ? (a & b) : (op == 9) ? (a | b) : (a ^ b);
                m_c = 0;
                m_ac = 0;
                set_szp(m_acc);
            end
            11: m_acc = 255 - a;
            12: begin m_c = (a >= 128); m_acc = (a * 2) % 256 + a / 128; end
            13: begin m_c = (a % 2 == 1); m_acc = a / 2 + (a % 2) * 128; end
            14: begin m_acc = (a * 2) % 256 + int'(m_c); m_c = (a >= 128); end
            15: begin m_acc = a / 2 + int'(m_c) * 128; m_c = (a % 2 == 1); end
            16: m_c = 1;
            17: m_c = !m_c;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0: return "R2";
            1, 2: return "R3";
            3, 4: return "R4";
            5: return "R5";
            6, 7: return "R6";
            8, 9, 10: return "R7";
            12, 13: return "R9";
            14, 15: return "R10";
            11, 16, 17: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic compare(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input string szp_tag);
        compare(tag, "acc", int'(acc_o), m_acc);
        compare(tag, "carry/aux", int'({flag_carry, flag_aux}), int'({m_c, m_ac}));
        compare(szp_tag, "sign/zero/parity", int'({flag_sign, flag_zero, flag_parity}),
                int'({m_s, m_z, m_p}));
    endtask

    task automatic apply(input int op, input int b);
        op_en = 1'b1;
        op_code = op[4:0];
        operand = b[7:0];
        model_op(op, b);
        @(negedge clk);
        if ((op >= 1 && op <= 10)) check_all(tag_of(op), "R8");
        else check_all(tag_of(op), tag_of(op));
    endtask

    task automatic idle(input int b);
        op_en = 1'b0;
        op_code = 5'd0;
        operand = b[7:0];
        @(negedge clk);
        check_all("R2", "R2");
    endtask

    task automatic force_carry(input bit c);
        apply(16, 0);
        if (!c) apply(17, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int bl[8] = '{0, 1, 15, 16, 127, 128, 200, 255};
        int two_ops[6] = '{1, 3, 5, 8, 9, 10};
        repeat (3) @(negedge clk);
        m_acc = 0; {m_s, m_z, m_c, m_p, m_ac} = '0;
        check_all("R1", "R1");
        apply(0, 8'hA5);
        apply(16, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_acc = 0; {m_s, m_z, m_c, m_p, m_ac} = '0;
        check_all("R1", "R1");

        // R2: idle cycles after state has been built up
        apply(0, 8'h3C);
        apply(1, 8'hF0);
        idle(8'hFF);
        idle(8'h00);

        // R12: unused codes
        for (int u = 18; u < 32; u += 3) apply(u, 8'h5A);

        // R11: carry set / complement sequence
        apply(17, 0); apply(17, 0); apply(16, 0); apply(16, 0); apply(17, 0);

        // R3 R4 R5 R7 R8: two-operand sweep
        for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 8; bi++) begin
                foreach (two_ops[k]) begin
                    apply(0, a);
                    apply(two_ops[k], bl[bi]);
                end
                for (int c = 0; c < 2; c++) begin
                    apply(0, a); force_carry(c[0]); apply(2, bl[bi]);
                    apply(0, a); force_carry(c[0]); apply(4, bl[bi]);
                end
            end
        end

        // R6 R9 R10 R11: unary sweep with both carry states
        for (int a = 0; a < 256; a++) begin
            for (int c = 0; c < 2; c++) begin
                force_carry(c[0]);
                apply(0, a); apply(6, 0);
                apply(0, a); apply(7, 0);
                apply(0, a); apply(11, 0);
                for (int r = 12; r < 16; r++) begin
                    apply(0, a); force_carry(c[0]); apply(r, 0);
                end
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    end

endmodule